// File: doc/BRIEF.md
# Three-State Digital Phase Comparator

This block compares the timing of two pulse trains, a reference train and a delayed variable train, and reports which of the two had its falling edge first. It is a synchronous phase-frequency comparator. Both inputs are asynchronous to the system clock. Each passes through a synchronizer chain and then a falling-edge detector. The edge events drive a three-state machine: idle, variable leading, and reference leading.

While one train leads, the block drives a level whose polarity names the leader. The drive lasts from the leading edge until the lagging edge, so its width follows the phase error. Averaged, this gives a linear response across plus or minus one full cycle. The drive sits behind an output enable, so the pin can float. The enable drops whenever a companion fine comparator reports that the error lies inside its window. In practice the block drives only during coarse acquisition and stays at high impedance once the fine loop takes over. Two status flags show the present state.

Top module: `tristate_phase_detector`

## Requirements
- R1: After reset, `varLeads`, `refLeads` and `pumpEnable` are all low.
- R2: From idle, a falling edge on `varIn` alone enters the variable-leading state (`varLeads`=1). A falling edge on `refIn` alone enters the reference-leading state (`refLeads`=1). Rising edges change nothing.
- R3: In a leading state, a falling edge on the other input returns the block to idle. This holds even when the leader's own input falls in the same cycle.
- R4: In a leading state, another falling edge of the leading input alone keeps the state unchanged. This gives frequency discrimination.
- R5: From idle, when both inputs fall in the same clock cycle, the block stays idle and no drive is produced.
- R6: An input level is sampled on a rising clock edge n. A falling edge is recognised when the level sampled at edge n is low and the level sampled at edge n-1 was high. That edge changes the state flags on rising edge n+2, with the default of two synchronizer stages.
- R7: `pumpEnable` is high only in a leading state while `inWindow` is low. A change of `inWindow` takes effect in the same cycle, without a clock edge.
- R8: While enabled, `pumpLevel` is 1 in the variable-leading state and 0 in the reference-leading state.
- R9: The state is a 2-bit code: 00 idle, 01 variable leading, 10 reference leading. `varLeads` and `refLeads` are never high together. The unused code 11 falls back to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Reference pulse train, asynchronous |
| varIn | input | 1 | Delayed variable pulse train, asynchronous |
| inWindow | input | 1 | High while the phase error is inside the fine comparator's window |
| pumpLevel | output | 1 | Drive polarity: 1 variable leads, 0 reference leads |
| pumpEnable | output | 1 | Output enable; low means high impedance |
| varLeads | output | 1 | State flag: variable leading |
| refLeads | output | 1 | State flag: reference leading |

## Verification
Two functions can fall in the same clock cycle.

The first is the recognition of both falling edges at once. The bench provokes this by lowering `refIn` and `varIn` on the same clock. It does so both from idle and while one input already leads. The first case is judged against staying idle; the second against returning to idle.

The second is the gating of the enable by `inWindow` in the same cycle that a leading state is entered. The bench raises `inWindow` across such an entry and expects the state flags to change while `pumpEnable` stays low.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef logic [1:0] pdState_t;
  localparam pdState_t ST_IDLE     = 2'b00;
  localparam pdState_t ST_VAR_LEAD = 2'b01;
  localparam pdState_t ST_REF_LEAD = 2'b10;

  typedef struct packed {
    logic varFall;
    logic refFall;
  } edgeEvents_t;

  typedef struct packed {
    logic driveHigh;
    logic driveLow;
  } pumpStrobes_t;
endpackage

// File: rtl/pd_edge_path.sv
module pd_edge_path
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         refIn,
  input  logic         varIn,
  input  logic         inWindow,
  input  pumpStrobes_t strobes,
  output edgeEvents_t  edges,
  output logic         pumpLevel,
  output logic         pumpEnable
);
  localparam int CHANNELS = 2;
  localparam int PIPE_W   = SYNC_STAGES + 1;

  logic [CHANNELS-1:0] rawIn;
  logic [CHANNELS-1:0] fallSeen;
  assign rawIn = {refIn, varIn};

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [PIPE_W-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[PIPE_W-2:0], rawIn[ch]};
    end
    assign fallSeen[ch] = pipe[PIPE_W-1] & ~pipe[PIPE_W-2];
  end

  assign edges.varFall = fallSeen[0];
  assign edges.refFall = fallSeen[1];

  assign pumpEnable = (strobes.driveHigh | strobes.driveLow) & ~inWindow;
  assign pumpLevel  = strobes.driveHigh;

  AST_VFALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    edges.varFall |=> !edges.varFall); // R6
  AST_RFALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    edges.refFall |=> !edges.refFall); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.driveHigh && strobes.driveLow)); // R9
  AST_WINDOW_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    pumpEnable |-> !inWindow); // R7
endmodule

// File: rtl/pd_state_ctrl.sv
module pd_state_ctrl
  import pd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  edgeEvents_t  edges,
  output pumpStrobes_t strobes,
  output logic         varLeads,
  output logic         refLeads
);
  pdState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (edges.varFall && !edges.refFall)      stateNext = ST_VAR_LEAD;
        else if (edges.refFall && !edges.varFall) stateNext = ST_REF_LEAD;
      end
      ST_VAR_LEAD: if (edges.refFall) stateNext = ST_IDLE;
      ST_REF_LEAD: if (edges.varFall) stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobes.driveHigh = (state == ST_VAR_LEAD);
  assign strobes.driveLow  = (state == ST_REF_LEAD);
  assign varLeads = strobes.driveHigh;
  assign refLeads = strobes.driveLow;

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'b11); // R9
  AST_ENTER_VAR: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && edges.varFall && !edges.refFall) |=> state == ST_VAR_LEAD); // R2
  AST_ENTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && edges.refFall && !edges.varFall) |=> state == ST_REF_LEAD); // R2
  AST_SIMUL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && edges.refFall && edges.varFall) |=> state == ST_IDLE); // R5
  AST_VAR_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VAR_LEAD && edges.refFall) |=> state == ST_IDLE); // R3
  AST_REF_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REF_LEAD && edges.varFall) |=> state == ST_IDLE); // R3
  AST_VAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VAR_LEAD && !edges.refFall) |=> state == ST_VAR_LEAD); // R4
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REF_LEAD && !edges.varFall) |=> state == ST_REF_LEAD); // R4
endmodule

// File: rtl/tristate_phase_detector.sv
module tristate_phase_detector
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic varIn,
  input  logic inWindow,
  output logic pumpLevel,
  output logic pumpEnable,
  output logic varLeads,
  output logic refLeads
);
  edgeEvents_t  edges;
  pumpStrobes_t strobes;

  pd_edge_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .refIn(refIn), .varIn(varIn), .inWindow(inWindow),
    .strobes(strobes), .edges(edges), .pumpLevel(pumpLevel), .pumpEnable(pumpEnable)
  );

  pd_state_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .edges(edges), .strobes(strobes),
    .varLeads(varLeads), .refLeads(refLeads)
  );
endmodule

// File: tb/sim_tristate_phase_detector.sv
module sim_tristate_phase_detector;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b1, varIn = 1'b1, inWindow = 1'b0;
  logic pumpLevel, pumpEnable, varLeads, refLeads;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tristate_phase_detector u0 (
    .clk(clk), .rstN(rstN), .refIn(refIn), .varIn(varIn), .inWindow(inWindow),
    .pumpLevel(pumpLevel), .pumpEnable(pumpEnable), .varLeads(varLeads), .refLeads(refLeads)
  );

  // behavioural model: 0 idle, 1 variable leads, 2 reference leads
  int mState = 0;
  bit refHist[$];
  bit varHist[$];
  string rule = "R1";

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    bit vf, rf;
    if (!rstN) begin
      mState = 0;
      refHist = '{0, 0, 0};
      varHist = '{0, 0, 0};
      rule = "R1";
    end else begin
      // R6: fall seen when sample n-3 high and n-2 low, applied at edge n
      vf = varHist[2] && !varHist[1];
      rf = refHist[2] && !refHist[1];
      rule = "R4";
      if (mState == 0) begin
        rule = "R2";
        if (vf && rf) rule = "R5";
        else if (vf) mState = 1;
        else if (rf) mState = 2;
      end else if (mState == 1 && rf) begin
        mState = 0; rule = "R3";
      end else if (mState == 2 && vf) begin
        mState = 0; rule = "R3";
      end
      refHist.push_front(refIn); void'(refHist.pop_back());
      varHist.push_front(varIn); void'(varHist.pop_back());
    end
    #2;
    if (rstN) begin
      check(rule, varLeads, mState == 1, "varLeads");
      check(rule, refLeads, mState == 2, "refLeads");
      check("R9", varLeads & refLeads, 0, "both flags");
      check("R7", pumpEnable, (mState != 0) && !inWindow, "pumpEnable");
      if (pumpEnable) check("R8", pumpLevel, mState == 1, "pumpLevel");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseVar(input int lowCycles);
    @(negedge clk); varIn = 1'b0;
    idle(lowCycles); varIn = 1'b1;
  endtask

  task automatic pulseRef(input int lowCycles);
    @(negedge clk); refIn = 1'b0;
    idle(lowCycles); refIn = 1'b1;
  endtask

  task automatic pulseBoth(input int lowCycles);
    @(negedge clk); refIn = 1'b0; varIn = 1'b0;
    idle(lowCycles); refIn = 1'b1; varIn = 1'b1;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    #1;
    check("R1", varLeads, 0, "reset varLeads");
    check("R1", refLeads, 0, "reset refLeads");
    check("R1", pumpEnable, 0, "reset pumpEnable");
    idle(4);
    // R6 latency: input low before edge n, flag changes at edge n+2
    @(negedge clk); varIn = 1'b0;
    @(posedge clk); #2 check("R6", varLeads, 0, "edge n");
    @(posedge clk); #2 check("R6", varLeads, 0, "edge n+1");
    @(posedge clk); #2 check("R6", varLeads, 1, "edge n+2");
    @(negedge clk); varIn = 1'b1;
    idle(3);
    // R3 return via reference edge
    pulseRef(2); idle(5);
    // R2 reference leads then R3 return via variable edge
    pulseRef(1); idle(6); pulseVar(3); idle(5);
    // R4 repeated leading edges
    pulseVar(2); idle(3); pulseVar(2); idle(3); pulseVar(1); idle(4);
    pulseRef(2); idle(4);
    pulseRef(2); idle(3); pulseRef(1); idle(4); pulseVar(2); idle(4);
    // R5 simultaneous from idle
    pulseBoth(2); idle(5);
    check("R5", varLeads | refLeads, 0, "simultaneous idle");
    // R3 simultaneous in leading state
    pulseVar(2); idle(4); pulseBoth(2); idle(5);
    pulseRef(2); idle(4); pulseBoth(2); idle(5);
    // R7 window gating across a state entry, toggled mid-lead
    @(negedge clk); inWindow = 1'b1;
    pulseVar(2); idle(5);
    check("R7", pumpEnable, 0, "in window");
    @(negedge clk); inWindow = 1'b0; #1;
    check("R7", pumpEnable, 1, "window left");
    check("R8", pumpLevel, 1, "var leads level");
    pulseRef(2); idle(5);
    pulseRef(2); idle(4);
    check("R8", pumpLevel, 0, "ref leads level");
    @(negedge clk); inWindow = 1'b1; #1;
    check("R7", pumpEnable, 0, "window entered");
    @(negedge clk); inWindow = 1'b0;
    pulseVar(1); idle(5);
    // close phase spacing: one cycle apart
    @(negedge clk); varIn = 1'b0;
    @(negedge clk); refIn = 1'b0;
    idle(2); varIn = 1'b1; refIn = 1'b1; idle(6);
    // R2 rising edges only: hold low across reset, then release
    @(negedge clk); rstN = 1'b0; varIn = 1'b0; refIn = 1'b0;
    idle(2); rstN = 1'b1; idle(3);
    varIn = 1'b1; refIn = 1'b1; idle(6);
    check("R2", varLeads | refLeads, 0, "rising edges only");
    // longer periodic run with drifting phase
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); refIn = 1'b0;
      idle(k % 5); varIn = 1'b0;
      idle(2); refIn = 1'b1; varIn = 1'b1;
      idle(4 + (k % 3));
    end
    idle(5);
    finish_run();
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule